// File: doc/BRIEF.md
# Keyed Minute-Resolution Watchdog Timer

This block is a software watchdog with a timeout counted in whole minutes. Software arms it and disarms it by writing one of two key bytes to a write-only lock register. A byte of any other value leaves the watchdog as it was. The timeout is loaded into an 8-bit timer register while the watchdog is disarmed. Once the watchdog is armed, the same register counts down by one each minute, and software reads it to learn how many minutes remain.

A prescaler turns the system clock into one tick per minute. The number of clock cycles in a minute is a parameter. When the count reaches zero, the block does three things: it latches an expiry flag, it raises the bite output for one cycle and it stops counting. Software refreshes the watchdog in three steps: disarm it, reload the timer, arm it again. The timer does not accept a new value while the watchdog runs.

The block has a simple strobe-based register port. A bus bridge sits in front of it, and a reset generator sits behind the bite output. Neither is part of this block.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed, the enable and status registers read 0, the timer register reads 1 and `wdog_bite` is low.
- R2: Writing 0x55 to the lock register (offset 0 from the base 0xE0) arms the watchdog from the next cycle. Writing 0xAA disarms it. Bit 0 of the enable register (offset 1) reads 1 while the watchdog is armed.
- R3: Writing any other byte to the lock register leaves the armed state unchanged, whether the watchdog is armed or disarmed. Reading the lock register returns 0.
- R4: A write to the timer register (offset 3) while the watchdog is disarmed loads the written number of minutes. A written value of 0 loads 1.
- R5: A write to the timer register while the watchdog is armed is ignored.
- R6: While the watchdog is armed, the timer decrements once every CYCLES_PER_MINUTE clock cycles. The first decrement comes CYCLES_PER_MINUTE cycles after the arming write takes effect, and a read of the timer register returns the minutes remaining. Disarming freezes the count and restarts the minute prescaler.
- R7: At the clock edge where an armed count goes from 1 to 0, bit 0 of the status register (offset 2) is set and `wdog_bite` is high for exactly that one cycle. After that the count stays at 0.
- R8: Reading the status register returns the expiry bit and clears it. If an expiry happens in the same cycle as the read, the bit stays set.
- R9: Read data appears on `reg_rdata` one clock after `reg_rd`. Addresses outside the four-register window read as 0, and so do the unused upper bits of the enable and status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| wdog_bite | output | 1 | One-cycle expiry pulse |

## Verification
Each result has a fixed latency:

| Result | When it is due |
|---|---|
| Key write | Takes effect at the edge that samples it |
| Read data | Valid after the edge that samples the read strobe |
| First timer decrement | CYCLES_PER_MINUTE edges after the arming edge |
| Bite | At the edge where the count reaches zero, so an N-minute timeout bites N times CYCLES_PER_MINUTE edges after arming |

The bench drives and samples on falling edges. It counts edges from the arming write, then places every timer read and every bite check on an edge number it has computed. It also sets up the case where a status read coincides with an expiry by putting the read strobe on exactly the expiry edge.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] wdk_byte_t;

  // Key bytes written to the lock register
  localparam wdk_byte_t KEY_ARM    = 8'h55;
  localparam wdk_byte_t KEY_DISARM = 8'hAA;

  // Timer value after reset
  localparam wdk_byte_t TIMER_DEFAULT = 8'd1;

  // Register select: the low two address bits inside the window
  typedef enum logic [1:0] {
    SEL_LOCK   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_TIMER  = 2'd3
  } wdk_sel_e;

  // A zero timeout is not meaningful, so it is promoted to one minute
  function automatic wdk_byte_t wdk_load(input wdk_byte_t v);
    return (v == '0) ? wdk_byte_t'(1) : v;
  endfunction

  // Count after one tick: decrement, saturating at zero
  function automatic wdk_byte_t wdk_step(input wdk_byte_t c);
    return (c == '0) ? c : c - wdk_byte_t'(1);
  endfunction

  // The tick on which the count moves from one to zero
  function automatic logic wdk_is_last(input wdk_byte_t c);
    return c == wdk_byte_t'(1);
  endfunction

endpackage

// File: rtl/wdk_key_decode.sv
module wdk_key_decode
  import wdk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lock_wr,
  input  wdk_byte_t wdata,
  output logic      armed
);

  logic arm_evt;
  logic disarm_evt;

  assign arm_evt    = lock_wr && (wdata == KEY_ARM);
  assign disarm_evt = lock_wr && (wdata == KEY_DISARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (arm_evt)    armed <= 1'b1;
    else if (disarm_evt) armed <= 1'b0;
  end

  // R2
  arm_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(lock_wr && (wdata == KEY_ARM)));

  // R3
  disarm_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(lock_wr && (wdata == KEY_DISARM)));

endmodule

// File: rtl/wdk_minute_prescaler.sv
module wdk_minute_prescaler #(
  parameter int unsigned CYCLES_PER_MINUTE = 32'd3_000_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned PW = (CYCLES_PER_MINUTE > 1) ? $clog2(CYCLES_PER_MINUTE) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYCLES_PER_MINUTE - 1);

  generate
    if (CYCLES_PER_MINUTE > 1) begin : g_count
      logic [PW-1:0] cyc;

      assign tick = run && (cyc == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cyc <= '0;
        else if (!run) cyc <= '0;
        else if (tick) cyc <= '0;
        else           cyc <= cyc + PW'(1);
      end

      // R6
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

      // R6
      restart_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> !tick);
    end else begin : g_every
      assign tick = run;
    end
  endgenerate

endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown
  import wdk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick,
  input  logic      load_wr,
  input  wdk_byte_t load_val,
  output wdk_byte_t count,
  output logic      expire_evt,
  output logic      bite
);

  logic load_ok;
  logic step_ok;

  assign load_ok    = load_wr && !run;
  assign step_ok    = run && tick;
  assign expire_evt = step_ok && wdk_is_last(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= TIMER_DEFAULT;
    else if (load_ok) count <= wdk_load(load_val);
    else if (step_ok) count <= wdk_step(count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bite <= 1'b0;
    else        bite <= expire_evt;
  end

  // R5
  frozen_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(count));

  // R6
  one_per_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && (count != '0)) |=> (count + wdk_byte_t'(1) == $past(count)));

  // R7
  bite_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> ((count == '0) && ($past(count) == wdk_byte_t'(1))));

  // R7
  bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> !bite);

  // R4
  never_loads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (count != '0));

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MINUTE = 32'd3_000_000_000,
  parameter int unsigned ADDR_W            = 8,
  parameter logic [ADDR_W-1:0] REG_BASE    = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              wdog_bite
);

  logic      hit;
  wdk_sel_e  sel;
  logic      lock_wr;
  logic      timer_wr;
  logic      status_rd;
  logic      armed;
  logic      tick;
  wdk_byte_t count;
  logic      expire_evt;
  logic      expired;
  wdk_byte_t rd_mux;

  assign hit       = (reg_addr[ADDR_W-1:2] == REG_BASE[ADDR_W-1:2]);
  assign sel       = wdk_sel_e'(reg_addr[1:0]);
  assign lock_wr   = reg_wr && hit && (sel == SEL_LOCK);
  assign timer_wr  = reg_wr && hit && (sel == SEL_TIMER);
  assign status_rd = reg_rd && hit && (sel == SEL_STATUS);

  wdk_key_decode i_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (lock_wr),
    .wdata   (reg_wdata),
    .armed   (armed)
  );

  wdk_minute_prescaler #(
    .CYCLES_PER_MINUTE (CYCLES_PER_MINUTE)
  ) i_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (armed),
    .tick  (tick)
  );

  wdk_countdown i_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (armed),
    .tick       (tick),
    .load_wr    (timer_wr),
    .load_val   (reg_wdata),
    .count      (count),
    .expire_evt (expire_evt),
    .bite       (wdog_bite)
  );

  // Expiry flag: a new expiry wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          expired <= 1'b0;
    else if (expire_evt) expired <= 1'b1;
    else if (status_rd)  expired <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (sel)
        SEL_LOCK:   rd_mux = '0;
        SEL_ENABLE: rd_mux = {7'd0, armed};
        SEL_STATUS: rd_mux = {7'd0, expired};
        SEL_TIMER:  rd_mux = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R7
  expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> expired);

  // R8
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !expire_evt) |=> !expired);

  // R9
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !hit) |=> (reg_rdata == '0));

endmodule

// File: tb/test_wdk_watchdog.sv
module test_wdk_watchdog;

  localparam int CLK_PERIOD = 10;
  localparam int M = 8;

  localparam logic [7:0] A_LOCK = 8'hE0;
  localparam logic [7:0] A_EN   = 8'hE1;
  localparam logic [7:0] A_STS  = 8'hE2;
  localparam logic [7:0] A_TMR  = 8'hE3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       wdog_bite;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdk_watchdog #(.CYCLES_PER_MINUTE(M)) i_wdk_watchdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wdog_bite (wdog_bite)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts bites over the window after arming; returns the count and the last edge index
  task automatic watch_bites(input int span, output int n, output int at);
    n = 0; at = -1;
    for (int k = 1; k <= span; k++) begin
      @(negedge clk);
      if (wdog_bite) begin n++; at = k; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n, at;
    int sweep [9] = '{1, 2, 3, 4, 5, 6, 17, 255, 0};

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    check("R1 bite", int'(wdog_bite), 0);
    rd(A_EN, v);  check("R1 enable", v, 0);
    rd(A_STS, v); check("R1 status", v, 0);
    rd(A_TMR, v); check("R1 timer", v, 1);

    // R3 lock register reads zero, bad key while disarmed
    rd(A_LOCK, v); check("R3 lock read", v, 0);
    wr(A_LOCK, 8'h12);
    rd(A_EN, v); check("R3 bad key disarmed", v, 0);

    // R9 unmapped addresses
    rd(8'h10, v); check("R9 unmapped", v, 0);
    rd(8'hE4, v); check("R9 beyond window", v, 0);

    // R4 R7 R8 sweep of timeouts: bite on edge T*M after arming
    foreach (sweep[i]) begin
      int t;
      int exp_t;
      t = sweep[i];
      exp_t = (t == 0) ? 1 : t;
      wr(A_LOCK, 8'hAA);
      wr(A_TMR, 8'(t));
      rd(A_TMR, v); check("R4 timer load", v, exp_t);
      rd(A_STS, v);
      wr(A_LOCK, 8'h55);
      watch_bites(exp_t * M + 3, n, at);
      check("R7 bite count", n, 1);
      check("R7 bite edge", at, exp_t * M);
      rd(A_STS, v); check("R7 status set", v, 1);
      rd(A_TMR, v); check("R7 timer stays zero", v, 0);
      rd(A_STS, v); check("R8 status cleared by read", v, 0);
    end

    // R6 mid-count reads and freeze on disarm
    wr(A_LOCK, 8'hAA);
    wr(A_TMR, 8'd3);
    wr(A_LOCK, 8'h55);
    wait_n(M + 1);
    rd(A_TMR, v); check("R6 after one minute", v, 2);
    wait_n(M - 4);
    rd(A_TMR, v); check("R6 after two minutes", v, 1);
    wr(A_LOCK, 8'hAA);
    watch_bites(3 * M, n, at);
    check("R6 no bite while disarmed", n, 0);
    rd(A_TMR, v); check("R6 count frozen", v, 1);

    // R6 prescaler restarts on re-arm
    wr(A_TMR, 8'd2);
    wr(A_LOCK, 8'h55);
    wait_n(5);
    wr(A_LOCK, 8'hAA);
    wr(A_LOCK, 8'h55);
    watch_bites(2 * M + 3, n, at);
    check("R6 restart bite edge", at, 2 * M);
    rd(A_STS, v);

    // R5 timer write ignored while armed; R3 bad key while armed; R2 flag
    wr(A_LOCK, 8'hAA);
    wr(A_TMR, 8'd5);
    wr(A_LOCK, 8'h55);
    wr(A_TMR, 8'd9);
    rd(A_TMR, v); check("R5 write ignored", v, 5);
    rd(A_EN, v);  check("R2 enable set", v, 1);
    wr(A_LOCK, 8'h00);
    rd(A_EN, v);  check("R3 bad key armed", v, 1);
    wr(A_LOCK, 8'h54);
    rd(A_EN, v);  check("R3 near key armed", v, 1);
    wr(A_LOCK, 8'hAA);
    rd(A_EN, v);  check("R2 enable cleared", v, 0);

    // R8 expiry and status read on the same edge: set wins
    wr(A_TMR, 8'd1);
    rd(A_STS, v);
    wr(A_LOCK, 8'h55);
    wait_n(M - 2);
    rd(A_STS, v); check("R8 read on expiry edge", v, 0);
    rd(A_STS, v); check("R8 set wins", v, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule